// File: doc/BRIEF.md
# Plug-and-Play Descriptor Table

This block is a read-only discovery area that holds one descriptor record for each agent on an on-chip bus. During bring-up, a registration port adds records one at a time. Each request is tagged as a master or a slave. Master records and slave records are kept in two separate regions, and each region has its own append counter. Once a region reaches its capacity, later requests for it are refused, and a sticky error flag records the refusal.

Software reads the 4 KiB area through a 32-bit read port. A read returns a byte, a halfword or a word, in big-endian lane order, one clock after the strobe. Each record takes 32 bytes. Two of its words are packed from the registered values:

- The identifier word holds the vendor and device codes.
- The memory-bar word holds the upper base-address bits, the size mask and the type code.

Every other word reads as zero. Bus writes are accepted at the port and discarded.

Top module: `pnp_table`

## Requirements
- R1: After reset (rst_ni low), every table location reads zero, and reg_err_o, mst_full_o and slv_full_o are all 0.
- R2: The k-th accepted master registration (k counted from 0) fills the record at byte offset 0x20*k. The k-th accepted slave registration fills the record at 0x800 + 0x20*k. The two counts are independent of each other.
- R3: Word 0 of a record (byte offset +0x00) reads vendor[7:0] in bits 31:24 and device[11:0] in bits 23:12, with bits 11:0 zero.
- R4: Word 4 of a record (byte offset +0x10) reads base[31:20] in bits 31:20, zero in bits 19:16, mask[11:0] in bits 15:4 and type[3:0] in bits 3:0.
- R5: Words 1, 2, 3, 5, 6 and 7 of every record, and every word of a record not yet filled, read zero.
- R6: A region holds at most RECS records (64 by default). A registration to a full region is refused and leaves the table unchanged. The region's full flag rises once its count reaches RECS. The other region continues to accept registrations.
- R7: reg_err_o rises in the cycle after a registration is refused and stays at 1 until reset.
- R8: rd_valid_o is 1 exactly in the cycle after rd_en_i is 1. rd_data_o updates only on a read and holds its value otherwise.
- R9: rd_size_i selects the access size. Code 00 returns byte (3 - addr[1:0]) of the word, in bits 7:0. Code 01 returns bits 31:16 when addr[1] = 0 and bits 15:0 when addr[1] = 1, in bits 15:0, and ignores addr[0]. Codes 10 and 11 return the whole word and ignore addr[1:0]. Unused upper result bits are zero.
- R10: Bus writes (wr_en_i with wr_addr_i and wr_data_i) leave every table location unchanged.
- R11: A read in the same cycle as a registration that fills the addressed word returns the word's contents from before that registration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_valid_i | input | 1 | One-cycle registration request |
| reg_slave_i | input | 1 | 1 selects the slave region, 0 the master region |
| reg_vendor_i | input | 8 | Vendor identifier |
| reg_device_i | input | 12 | Device identifier |
| reg_base_i | input | 32 | Base address (only bits 31:20 are stored) |
| reg_mask_i | input | 12 | Address mask |
| reg_type_i | input | 4 | Memory-bar type code |
| reg_err_o | output | 1 | Sticky refusal flag |
| mst_full_o | output | 1 | Master region full |
| slv_full_o | output | 1 | Slave region full |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 12 | Read byte address |
| rd_size_i | input | 2 | Access size code |
| rd_data_o | output | 32 | Read result |
| rd_valid_o | output | 1 | Read result valid |
| wr_en_i | input | 1 | Bus write strobe (discarded) |
| wr_addr_i | input | 12 | Bus write address (discarded) |
| wr_data_i | input | 32 | Bus write data (discarded) |

## Verification
The assertions check, on every cycle:

- the one-cycle read latency and that read data holds between reads;
- zero extension of byte and halfword results;
- zero data from the unused record words;
- the stickiness of the error flag and of both full flags;
- that a request to a full region raises the error.

Only the bench's scenarios can show the rest:

- the exact record packing and the slot placement of interleaved master and slave registrations;
- the big-endian lane order;
- that bus writes and refused requests leave the contents untouched;
- that a read colliding with a registration returns the old word.

// File: rtl/pnp_pkg.sv
package pnp_pkg;
  localparam int ADDR_W = 12;

  typedef struct packed {
    logic [7:0]  vendor;
    logic [11:0] device;
  } pnp_id_t;

  typedef struct packed {
    logic [11:0] base_hi;
    logic [11:0] mask;
    logic [3:0]  kind;
  } pnp_bar_t;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  function automatic logic [31:0] id_word(pnp_id_t id);
    return {id.vendor, id.device, 12'h000};
  endfunction

  function automatic logic [31:0] bar_word(pnp_bar_t b);
    return {b.base_hi, 4'h0, b.mask, b.kind};
  endfunction
endpackage

// File: rtl/pnp_alloc.sv
module pnp_alloc #(
  parameter int RECS  = 64,
  parameter int IDX_W = $clog2(RECS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       sel_i,
  output logic [1:0]                 we_o,
  output logic [1:0][IDX_W-1:0]      idx_o,
  output logic [1:0]                 full_o,
  output logic                       err_o
);
  localparam int CNT_W = $clog2(RECS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RECS);

  logic [1:0][CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < 2; g++) begin : g_region
    assign full_o[g] = (cnt_q[g] == LIMIT);
    assign we_o[g]   = req_i && (sel_i == 1'(g)) && !full_o[g];
    assign idx_o[g]  = cnt_q[g][IDX_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q[g] <= '0;
      else if (we_o[g]) cnt_q[g] <= cnt_q[g] + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       err_o <= 1'b0;
    else if (req_i && full_o[sel_i])   err_o <= 1'b1;
  end
endmodule

// File: rtl/pnp_store.sv
module pnp_store
  import pnp_pkg::*;
#(
  parameter int RECS  = 64,
  parameter int IDX_W = $clog2(RECS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  pnp_id_t          id_i,
  input  pnp_bar_t         bar_i,
  input  logic [IDX_W-1:0] ridx_i,
  output pnp_id_t          id_o,
  output pnp_bar_t         bar_o
);
  pnp_id_t  id_q  [RECS];
  pnp_bar_t bar_q [RECS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RECS; i++) begin
        id_q[i]  <= '0;
        bar_q[i] <= '0;
      end
    end else if (we_i) begin
      id_q[widx_i]  <= id_i;
      bar_q[widx_i] <= bar_i;
    end
  end

  assign id_o  = id_q[ridx_i];
  assign bar_o = bar_q[ridx_i];
endmodule

// File: rtl/pnp_lane.sv
module pnp_lane
  import pnp_pkg::*;
(
  input  logic [31:0] word_i,
  input  logic [1:0]  off_i,
  input  logic [1:0]  size_i,
  output logic [31:0] data_o
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  // big-endian: offset 0 is the most significant byte
  always_comb begin
    unique case (off_i)
      2'd0:    byte_sel = word_i[31:24];
      2'd1:    byte_sel = word_i[23:16];
      2'd2:    byte_sel = word_i[15:8];
      default: byte_sel = word_i[7:0];
    endcase
    half_sel = off_i[1] ? word_i[15:0] : word_i[31:16];
    if (size_i == SZ_BYTE)      data_o = {24'h0, byte_sel};
    else if (size_i == SZ_HALF) data_o = {16'h0, half_sel};
    else                        data_o = word_i;
  end
endmodule

// File: rtl/pnp_table.sv
module pnp_table
  import pnp_pkg::*;
#(
  parameter int RECS = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_valid_i,
  input  logic        reg_slave_i,
  input  logic [7:0]  reg_vendor_i,
  input  logic [11:0] reg_device_i,
  input  logic [31:0] reg_base_i,
  input  logic [11:0] reg_mask_i,
  input  logic [3:0]  reg_type_i,
  output logic        reg_err_o,
  output logic        mst_full_o,
  output logic        slv_full_o,
  input  logic        rd_en_i,
  input  logic [11:0] rd_addr_i,
  input  logic [1:0]  rd_size_i,
  output logic [31:0] rd_data_o,
  output logic        rd_valid_o,
  input  logic        wr_en_i,
  input  logic [11:0] wr_addr_i,
  input  logic [31:0] wr_data_i
);
  localparam int IDX_W   = $clog2(RECS);
  localparam int REC_LSB = 5;                 // 32-byte records
  localparam int REC_W   = ADDR_W - 1 - REC_LSB;
  localparam logic [REC_W:0] RECS_L = RECS[REC_W:0];

  // the table is read-only from the bus
  logic unused_bus;
  assign unused_bus = ^{wr_en_i, wr_addr_i, wr_data_i, reg_base_i[19:0]};

  logic [1:0]            we;
  logic [1:0][IDX_W-1:0] widx;
  logic [1:0]            full;
  pnp_id_t               new_id;
  pnp_bar_t              new_bar;

  assign new_id  = '{vendor: reg_vendor_i, device: reg_device_i};
  assign new_bar = '{base_hi: reg_base_i[31:20], mask: reg_mask_i, kind: reg_type_i};

  pnp_alloc #(.RECS(RECS), .IDX_W(IDX_W)) u_alloc (
    .clk_i, .rst_ni,
    .req_i (reg_valid_i),
    .sel_i (reg_slave_i),
    .we_o  (we),
    .idx_o (widx),
    .full_o(full),
    .err_o (reg_err_o)
  );

  assign mst_full_o = full[0];
  assign slv_full_o = full[1];

  logic             rd_region;
  logic [REC_W-1:0] rd_rec;
  logic [2:0]       rd_wsel;
  logic             rec_ok;

  assign rd_region = rd_addr_i[ADDR_W-1];
  assign rd_rec    = rd_addr_i[ADDR_W-2:REC_LSB];
  assign rd_wsel   = rd_addr_i[REC_LSB-1:2];
  assign rec_ok    = ({1'b0, rd_rec} < RECS_L);

  pnp_id_t  rid  [2];
  pnp_bar_t rbar [2];

  for (genvar g = 0; g < 2; g++) begin : g_store
    pnp_store #(.RECS(RECS), .IDX_W(IDX_W)) u_store (
      .clk_i, .rst_ni,
      .we_i  (we[g]),
      .widx_i(widx[g]),
      .id_i  (new_id),
      .bar_i (new_bar),
      .ridx_i(rd_rec[IDX_W-1:0]),
      .id_o  (rid[g]),
      .bar_o (rbar[g])
    );
  end

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (rec_ok) begin
      if (rd_wsel == 3'd0)      rd_word = id_word(rid[rd_region]);
      else if (rd_wsel == 3'd4) rd_word = bar_word(rbar[rd_region]);
    end
  end

  logic [31:0] lane_data;
  pnp_lane u_lane (
    .word_i(rd_word),
    .off_i (rd_addr_i[1:0]),
    .size_i(rd_size_i),
    .data_o(lane_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= lane_data;
    end
  end
endmodule

// File: rtl/pnp_table_chk.sv
module pnp_table_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_valid_i,
  input logic        reg_slave_i,
  input logic        reg_err_o,
  input logic        mst_full_o,
  input logic        slv_full_o,
  input logic        rd_en_i,
  input logic [11:0] rd_addr_i,
  input logic [1:0]  rd_size_i,
  input logic [31:0] rd_data_o,
  input logic        rd_valid_o
);
  // R8
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  // R8
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_valid_o && $stable(rd_data_o)));
  // R9
  byte_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_size_i == 2'b00) |=> rd_data_o[31:8] == 24'h0);
  // R9
  half_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_size_i == 2'b01) |=> rd_data_o[31:16] == 16'h0);
  // R5
  unused_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i[4:2] != 3'd0 && rd_addr_i[4:2] != 3'd4) |=> rd_data_o == 32'h0);
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |=> reg_err_o);
  // R7
  refuse_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_i && (reg_slave_i ? slv_full_o : mst_full_o)) |=> reg_err_o);
  // R6
  full_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_full_o |=> mst_full_o) and (slv_full_o |=> slv_full_o));
endmodule

bind pnp_table pnp_table_chk u_chk (.*);

// File: tb/pnp_table_test.sv
module pnp_table_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_valid_i = 1'b0, reg_slave_i = 1'b0;
  logic [7:0]  reg_vendor_i = '0;
  logic [11:0] reg_device_i = '0;
  logic [31:0] reg_base_i = '0;
  logic [11:0] reg_mask_i = '0;
  logic [3:0]  reg_type_i = '0;
  logic        reg_err_o, mst_full_o, slv_full_o;
  logic        rd_en_i = 1'b0;
  logic [11:0] rd_addr_i = '0;
  logic [1:0]  rd_size_i = '0;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;
  logic        wr_en_i = 1'b0;
  logic [11:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pnp_table uut (
    .clk_i(clk), .rst_ni, .reg_valid_i, .reg_slave_i, .reg_vendor_i, .reg_device_i,
    .reg_base_i, .reg_mask_i, .reg_type_i, .reg_err_o, .mst_full_o, .slv_full_o,
    .rd_en_i, .rd_addr_i, .rd_size_i, .rd_data_o, .rd_valid_o,
    .wr_en_i, .wr_addr_i, .wr_data_i
  );

  typedef struct packed {
    logic [11:0] addr;
    logic [1:0]  size;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{12'h000, 2'b10, 32'h0100A000},  // R2 R3 master 0
    '{12'h010, 2'b10, 32'h4000FFF2},  // R4
    '{12'h020, 2'b10, 32'hA53C7000},  // R2 master 1
    '{12'h030, 2'b10, 32'h8010F003},  // R4
    '{12'h800, 2'b10, 32'h1EABC000},  // R2 slave 0
    '{12'h810, 2'b10, 32'hFFF00F01},
    '{12'h820, 2'b10, 32'h80001000},
    '{12'h830, 2'b10, 32'h0010001F},
    '{12'h004, 2'b10, 32'h00000000},  // R5
    '{12'h83C, 2'b10, 32'h00000000},  // R5
    '{12'h040, 2'b10, 32'h00000000},  // R5 unfilled
    '{12'h850, 2'b10, 32'h00000000},  // R5 unfilled
    '{12'h020, 2'b00, 32'h000000A5},  // R9 bytes
    '{12'h021, 2'b00, 32'h0000003C},
    '{12'h022, 2'b00, 32'h00000070},
    '{12'h023, 2'b00, 32'h00000000},
    '{12'h811, 2'b00, 32'h000000F0},
    '{12'h813, 2'b00, 32'h00000001},
    '{12'h030, 2'b01, 32'h00008010},  // R9 halves
    '{12'h032, 2'b01, 32'h0000F003},
    '{12'h033, 2'b01, 32'h0000F003},
    '{12'h012, 2'b11, 32'h4000FFF2}   // R9 word ignores offset
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_reg(input logic slv, input logic [7:0] ven, input logic [11:0] dev,
                        input logic [31:0] base, input logic [11:0] msk, input logic [3:0] typ);
    @(negedge clk);
    reg_valid_i = 1'b1; reg_slave_i = slv; reg_vendor_i = ven; reg_device_i = dev;
    reg_base_i = base; reg_mask_i = msk; reg_type_i = typ;
    @(negedge clk);
    reg_valid_i = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; rd_addr_i = a; rd_size_i = sz;
    @(negedge clk);
    rd_en_i = 1'b0;
    if (!rd_valid_o) begin
      checks++; fails++;
      $display("FAIL R8: actual rd_valid 0 expected 1");
    end
    d = rd_data_o;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    check("R1 err", {31'h0, reg_err_o}, 32'h0);
    check("R1 full", {30'h0, mst_full_o, slv_full_o}, 32'h0);
    do_read(12'h000, 2'b10, d); check("R1 rd 000", d, 32'h0);
    do_read(12'h810, 2'b10, d); check("R1 rd 810", d, 32'h0);

    // interleaved registrations: R2 separate counters
    do_reg(1'b0, 8'h01, 12'h00A, 32'h4000_0000, 12'hFFF, 4'h2);
    do_reg(1'b1, 8'h1E, 12'hABC, 32'hFFF0_0000, 12'h0F0, 4'h1);
    do_reg(1'b0, 8'hA5, 12'h3C7, 32'h8012_3456, 12'hF00, 4'h3);
    do_reg(1'b1, 8'h80, 12'h001, 32'h0010_0000, 12'h001, 4'hF);

    for (int i = 0; i < NV; i++) begin
      do_read(VECS[i].addr, VECS[i].size, d);
      check($sformatf("R2-R5/R9 vec %0d", i), d, VECS[i].exp);
    end

    // R8 data holds while idle
    repeat (3) @(negedge clk);
    check("R8 hold", rd_data_o, 32'h4000FFF2);
    check("R8 valid low", {31'h0, rd_valid_o}, 32'h0);

    // R10 bus writes ignored
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 12'h000; wr_data_i = 32'hDEADBEEF;
    @(negedge clk);
    wr_addr_i = 12'h044; wr_data_i = 32'h12345678;
    @(negedge clk);
    wr_en_i = 1'b0;
    do_read(12'h000, 2'b10, d); check("R10 rd 000", d, 32'h0100A000);
    do_read(12'h044, 2'b10, d); check("R10 rd 044", d, 32'h0);

    // R11 same-cycle registration and read return old contents
    @(negedge clk);
    reg_valid_i = 1'b1; reg_slave_i = 1'b0; reg_vendor_i = 8'h22; reg_device_i = 12'h222;
    reg_base_i = 32'h2220_0000; reg_mask_i = 12'h222; reg_type_i = 4'h2;
    rd_en_i = 1'b1; rd_addr_i = 12'h040; rd_size_i = 2'b10;
    @(negedge clk);
    reg_valid_i = 1'b0; rd_en_i = 1'b0;
    check("R11 old", rd_data_o, 32'h0);
    do_read(12'h040, 2'b10, d); check("R11 new", d, 32'h22222000);
    do_read(12'h050, 2'b10, d); check("R11 new bar", d, 32'h22202222);

    // R6 fill master region (3 used)
    for (int k = 3; k < 64; k++)
      do_reg(1'b0, 8'(k), 12'(12'h100 + k), 32'h0, 12'h0, 4'h0);
    check("R6 mst full", {31'h0, mst_full_o}, 32'h1);
    check("R6 slv not full", {31'h0, slv_full_o}, 32'h0);
    check("R7 no err yet", {31'h0, reg_err_o}, 32'h0);
    do_read(12'h7E0, 2'b10, d); check("R6 last slot", d, 32'h3F13F000);

    do_reg(1'b0, 8'hEE, 12'hEEE, 32'hEEE0_0000, 12'hEEE, 4'hE);
    check("R7 err set", {31'h0, reg_err_o}, 32'h1);
    do_read(12'h7E0, 2'b10, d); check("R6 refused unchanged", d, 32'h3F13F000);
    do_read(12'h000, 2'b10, d); check("R6 slot0 unchanged", d, 32'h0100A000);
    do_read(12'h840, 2'b10, d); check("R6 no leak to slaves", d, 32'h0);

    do_reg(1'b1, 8'h33, 12'h456, 32'h3330_0000, 12'h0AA, 4'h5);
    do_read(12'h840, 2'b10, d); check("R6 slave still accepts", d, 32'h33456000);
    do_read(12'h850, 2'b10, d); check("R4 slave bar", d, 32'h33300AA5);
    check("R7 err sticky", {31'h0, reg_err_o}, 32'h1);

    // R1 reset again
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    check("R1 err cleared", {31'h0, reg_err_o}, 32'h0);
    check("R1 full cleared", {31'h0, mst_full_o}, 32'h0);
    do_read(12'h7E0, 2'b10, d); check("R1 table cleared", d, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule